// File: doc/BRIEF.md
# Half-Word Host to Word Register Bridge

This block sits between a 16-bit host data path and a 32-bit internal register bus whose byte order is little endian. Every 32-bit register access from the host takes two 16-bit accesses, one to each half of the word, and the two may come in either order. For a write, the block collects both halves and then issues a single 32-bit internal write. For a read, the first access of a pair fetches the whole word once and keeps it. The second access is then answered from that copy.

The block keeps separate pairing state for reads and for writes. A second write to the half already held throws the pair away. A second read to the same half gets an invalid, flagged reply, and the read pairing starts again. A read whose internal reply is marked as coming from a 16-bit-readable register is complete by itself. Each host access carries its own byte-order select. That select, together with address bit 1, decides which internal half the access touches and whether the two bytes of that half are swapped.

Both host requests and internal requests use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. A request must hold all its fields until it is accepted. The host may hold off a read reply by keeping `h_rsp_ready` low, and the reply then stays fixed. While an internal access or a host reply is outstanding, `h_req_ready` is low, so at most one host access is in flight at a time. Internal read data arrives on `i_rsp_valid`, no earlier than the cycle after the read request was accepted, and it cannot be held off.

Top module: `hbr_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `h_req_ready` is 1, and `h_rsp_valid` and `i_req_valid` are 0.
- R2: A host write to one half followed by a host write to the other half of the same word address (`h_req_addr[AW-1:2]`), in either order, produces exactly one internal write. `i_req_valid` and `i_req_write` are high in the cycle right after the second write is accepted. The address is the word address, and the data holds both halves.
- R3: A host write that opens a pair issues no internal access.
- R4: A write to the internal half that is already held by an open write pair drops both that write and the held half, with no internal write. The next write starts a new pair.
- R5: If the word address of a write differs from that of the open write pair, the held half is dropped and the current write becomes the first half of a new pair. The new pair's internal write contains no data from the dropped half.
- R6: A read that does not complete an open read pair issues one internal read of its word address. `i_req_valid` is high in the cycle after acceptance. The host reply (`h_rsp_valid`, `h_rsp_void`=0) appears in the cycle after `i_rsp_valid`.
- R7: A read to the other half of the same word as an open read pair is answered from the stored word with no internal read. `h_rsp_valid` is high in the cycle after acceptance.
- R8: A read to the same half and word as an open read pair issues no internal read. It is answered in the next cycle with `h_rsp_void`=1 and `h_rsp_data`=0 and closes the pair, so the read after it issues a new internal read.
- R9: When the internal reply carries `i_rsp_hw16`=1, no read pair is left open, and the next read of that word, to either half, issues a new internal read.
- R10: With `h_req_bigend`=0, A1=0 maps to internal bits 15:0 and A1=1 maps to bits 31:16. Host bits 15:8 carry the higher-addressed byte of that half (for example, writes 16'h2211 at A1=0 and 16'h4433 at A1=1 form 32'h44332211).
- R11: With `h_req_bigend`=1, A1=0 maps to internal bits 31:16 and A1=1 maps to bits 15:0, with the two bytes of the half swapped. Pairing uses the internal half (for example, writes 16'hAABB at A1=0 and 16'hCCDD at A1=1 form 32'hBBAADDCC).
- R12: `h_req_ready` is 0 while `i_req_valid` or `h_rsp_valid` is high. A stalled internal request keeps its fields stable until `i_req_ready`. A stalled host reply keeps `h_rsp_data` and `h_rsp_void` until `h_rsp_ready`.
- R13: Read pairing and write pairing are independent. An access of one kind does not open, close or change a pair of the other kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host access request valid |
| h_req_ready | output | 1 | Bridge can take a host access |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | AW-1 | Host half-word address, bits AW-1:1 (bit 1 selects the half, the rest is the word address) |
| h_req_wdata | input | 16 | Host write data |
| h_req_bigend | input | 1 | Byte-order select for this access, 1 = big endian |
| h_rsp_valid | output | 1 | Host read reply valid |
| h_rsp_ready | input | 1 | Host takes the read reply |
| h_rsp_data | output | 16 | Host read data |
| h_rsp_void | output | 1 | Reply is invalid (repeated half), data is 0 |
| i_req_valid | output | 1 | Internal request valid |
| i_req_ready | input | 1 | Internal bus takes the request |
| i_req_write | output | 1 | Internal request is a write |
| i_req_addr | output | AW-2 | Internal word address |
| i_req_wdata | output | 32 | Internal write data, little endian |
| i_rsp_valid | input | 1 | Internal read data valid |
| i_rsp_data | input | 32 | Internal read data |
| i_rsp_hw16 | input | 1 | Register read is complete as a single 16-bit access |

## Verification
A write that completes a pair raises `i_req_valid` in the first cycle after it is accepted. A write that does not complete a pair leaves it low in that same cycle. A read served from the stored word or flagged void shows `h_rsp_valid` exactly one cycle after acceptance. A fetching read replies one cycle after the internal data, with a variable wait before it because the bench model stalls `i_req_ready` at random. Inputs are driven and outputs sampled on falling clock edges. The bench counts the cycles from the accepting rising edge, so every check reads a value that has settled at the cycle where the requirement places it.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  localparam int unsigned HBR_BYTE_W = 8;
  localparam int unsigned HBR_HALF_W = 16;
  localparam int unsigned HBR_WORD_W = 32;
  localparam int unsigned HBR_LANES  = HBR_HALF_W / HBR_BYTE_W;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } hbr_half_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_ISSUE = 3'd1,
    ST_RD_ISSUE = 3'd2,
    ST_RD_WAIT  = 3'd3,
    ST_RSP      = 3'd4
  } hbr_state_e;

endpackage

// File: rtl/hbr_lane_map.sv
module hbr_lane_map
  import hbr_pkg::*;
(
  input  logic                  a1,
  input  logic                  bigend,
  input  logic [HBR_HALF_W-1:0] host_half,
  input  logic [HBR_WORD_W-1:0] word,
  output hbr_half_e             phys_half,
  output logic [HBR_HALF_W-1:0] int_half,
  output logic [HBR_HALF_W-1:0] host_view
);

  logic [HBR_HALF_W-1:0] word_half;

  // Big-endian accesses address the opposite internal half.
  assign phys_half = hbr_half_e'(a1 ^ bigend);
  assign word_half = (phys_half == HALF_HI) ? word[HBR_WORD_W-1:HBR_HALF_W]
                                            : word[HBR_HALF_W-1:0];

  // Byte lanes inside the half are mirrored in big-endian mode.
  for (genvar b = 0; b < HBR_LANES; b++) begin : g_lane
    localparam int unsigned MIR = HBR_LANES - 1 - b;
    assign int_half[b*HBR_BYTE_W +: HBR_BYTE_W] =
      bigend ? host_half[MIR*HBR_BYTE_W +: HBR_BYTE_W]
             : host_half[b*HBR_BYTE_W +: HBR_BYTE_W];
    assign host_view[b*HBR_BYTE_W +: HBR_BYTE_W] =
      bigend ? word_half[MIR*HBR_BYTE_W +: HBR_BYTE_W]
             : word_half[b*HBR_BYTE_W +: HBR_BYTE_W];
  end

endmodule

// File: rtl/hbr_wr_pair.sv
module hbr_wr_pair
  import hbr_pkg::*;
#(
  parameter int unsigned WAW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic [WAW-1:0]        waddr,
  input  hbr_half_e             half,
  input  logic [HBR_HALF_W-1:0] int_half,
  output logic                  done,
  output logic [WAW-1:0]        out_addr,
  output logic [HBR_WORD_W-1:0] out_word
);

  logic                  pend_q;
  hbr_half_e             half_q;
  logic [WAW-1:0]        addr_q;
  logic [HBR_WORD_W-1:0] buf_q;
  logic                  same_word;

  assign same_word = pend_q && (addr_q == waddr);
  assign done      = acc && same_word && (half != half_q);
  assign out_addr  = addr_q;
  assign out_word  = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      half_q <= HALF_LO;
      addr_q <= '0;
      buf_q  <= '0;
    end else if (acc) begin
      if (same_word) begin
        // Either the pair completes or a repeated half kills it.
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        half_q <= half;
        addr_q <= waddr;
      end
      if (half == HALF_HI) buf_q[HBR_WORD_W-1:HBR_HALF_W] <= int_half;
      else                 buf_q[HBR_HALF_W-1:0]          <= int_half;
    end
  end

endmodule

// File: rtl/hbr_rd_pair.sv
module hbr_rd_pair
  import hbr_pkg::*;
#(
  parameter int unsigned WAW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic [WAW-1:0]        waddr,
  input  hbr_half_e             half,
  input  logic                  load,
  input  logic [HBR_WORD_W-1:0] load_word,
  input  logic                  load_hw16,
  output logic                  fetch,
  output logic                  void_rd,
  output logic [HBR_WORD_W-1:0] held_word
);

  logic                  pend_q;
  hbr_half_e             half_q;
  logic [WAW-1:0]        addr_q;
  logic [HBR_WORD_W-1:0] word_q;
  logic                  hit;

  assign hit       = pend_q && (addr_q == waddr);
  assign fetch     = acc && !hit;
  assign void_rd   = acc && hit && (half == half_q);
  assign held_word = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      half_q <= HALF_LO;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      if (acc) begin
        pend_q <= 1'b0;
        if (!hit) begin
          half_q <= half;
          addr_q <= waddr;
        end
      end
      if (load) begin
        word_q <= load_word;
        pend_q <= !load_hw16;
      end
    end
  end

endmodule

// File: rtl/hbr_bridge.sv
module hbr_bridge
  import hbr_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  h_req_valid,
  output logic                  h_req_ready,
  input  logic                  h_req_write,
  input  logic [AW-1:1]         h_req_addr,
  input  logic [HBR_HALF_W-1:0] h_req_wdata,
  input  logic                  h_req_bigend,
  output logic                  h_rsp_valid,
  input  logic                  h_rsp_ready,
  output logic [HBR_HALF_W-1:0] h_rsp_data,
  output logic                  h_rsp_void,
  output logic                  i_req_valid,
  input  logic                  i_req_ready,
  output logic                  i_req_write,
  output logic [AW-3:0]         i_req_addr,
  output logic [HBR_WORD_W-1:0] i_req_wdata,
  input  logic                  i_rsp_valid,
  input  logic [HBR_WORD_W-1:0] i_rsp_data,
  input  logic                  i_rsp_hw16
);

  localparam int unsigned WAW = AW - 2;

  hbr_state_e            state_q;
  logic                  acc, wr_acc, rd_acc;
  logic [WAW-1:0]        cur_waddr;
  logic                  waiting;

  logic                  map_a1, map_be;
  logic [HBR_WORD_W-1:0] map_word;
  hbr_half_e             map_half;
  logic [HBR_HALF_W-1:0] map_int_half, map_view;

  logic                  wr_done;
  logic [WAW-1:0]        wr_addr;
  logic [HBR_WORD_W-1:0] wr_word;

  logic                  rd_fetch, rd_void, rd_load;
  logic [HBR_WORD_W-1:0] rd_word;

  logic [WAW-1:0]        rd_addr_q;
  logic                  rd_a1_q, rd_be_q;
  logic [HBR_HALF_W-1:0] rsp_data_q;
  logic                  rsp_void_q;

  assign h_req_ready = (state_q == ST_IDLE);
  assign acc         = h_req_valid && h_req_ready;
  assign wr_acc      = acc && h_req_write;
  assign rd_acc      = acc && !h_req_write;
  assign cur_waddr   = h_req_addr[AW-1:2];
  assign waiting     = (state_q == ST_RD_WAIT);

  // One lane map serves the live access and, while waiting, the fetched word.
  assign map_a1   = waiting ? rd_a1_q    : h_req_addr[1];
  assign map_be   = waiting ? rd_be_q    : h_req_bigend;
  assign map_word = waiting ? i_rsp_data : rd_word;

  hbr_lane_map u_map (
    .a1        (map_a1),
    .bigend    (map_be),
    .host_half (h_req_wdata),
    .word      (map_word),
    .phys_half (map_half),
    .int_half  (map_int_half),
    .host_view (map_view)
  );

  hbr_wr_pair #(.WAW(WAW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (wr_acc),
    .waddr    (cur_waddr),
    .half     (map_half),
    .int_half (map_int_half),
    .done     (wr_done),
    .out_addr (wr_addr),
    .out_word (wr_word)
  );

  assign rd_load = waiting && i_rsp_valid;

  hbr_rd_pair #(.WAW(WAW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (rd_acc),
    .waddr     (cur_waddr),
    .half      (map_half),
    .load      (rd_load),
    .load_word (i_rsp_data),
    .load_hw16 (i_rsp_hw16),
    .fetch     (rd_fetch),
    .void_rd   (rd_void),
    .held_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rd_addr_q  <= '0;
      rd_a1_q    <= 1'b0;
      rd_be_q    <= 1'b0;
      rsp_data_q <= '0;
      rsp_void_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_acc && wr_done) begin
            state_q <= ST_WR_ISSUE;
          end else if (rd_acc) begin
            if (rd_fetch) begin
              rd_addr_q <= cur_waddr;
              rd_a1_q   <= h_req_addr[1];
              rd_be_q   <= h_req_bigend;
              state_q   <= ST_RD_ISSUE;
            end else begin
              rsp_data_q <= rd_void ? '0 : map_view;
              rsp_void_q <= rd_void;
              state_q    <= ST_RSP;
            end
          end
        end
        ST_WR_ISSUE: if (i_req_ready) state_q <= ST_IDLE;
        ST_RD_ISSUE: if (i_req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (i_rsp_valid) begin
            rsp_data_q <= map_view;
            rsp_void_q <= 1'b0;
            state_q    <= ST_RSP;
          end
        end
        ST_RSP:      if (h_rsp_ready) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  assign i_req_valid = (state_q == ST_WR_ISSUE) || (state_q == ST_RD_ISSUE);
  assign i_req_write = (state_q == ST_WR_ISSUE);
  assign i_req_addr  = i_req_write ? wr_addr : rd_addr_q;
  assign i_req_wdata = wr_word;
  assign h_rsp_valid = (state_q == ST_RSP);
  assign h_rsp_data  = rsp_data_q;
  assign h_rsp_void  = rsp_void_q;

endmodule

// File: rtl/hbr_bridge_chk.sv
module hbr_bridge_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req_valid,
  input logic          h_req_ready,
  input logic          h_req_write,
  input logic [AW-1:1] h_req_addr,
  input logic          h_rsp_valid,
  input logic          h_rsp_ready,
  input logic [15:0]   h_rsp_data,
  input logic          h_rsp_void,
  input logic          i_req_valid,
  input logic          i_req_ready,
  input logic          i_req_write,
  input logic [AW-3:0] i_req_addr,
  input logic [31:0]   i_req_wdata,
  input logic          i_rsp_valid
);

  AST_WR_AFTER_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_req_valid) && i_req_write |-> $past(h_req_valid && h_req_ready && h_req_write)); // R2

  AST_WR_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_req_valid) && i_req_write |-> i_req_addr == $past(h_req_addr[AW-1:2])); // R2

  AST_RD_AFTER_HOST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_req_valid) && !i_req_write |-> $past(h_req_valid && h_req_ready && !h_req_write)); // R6

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_rsp_valid) |-> $past(i_rsp_valid) || $past(h_req_valid && h_req_ready && !h_req_write)); // R7

  AST_VOID_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid && h_rsp_void |-> h_rsp_data == 16'h0000); // R8

  AST_BUSY_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid || h_rsp_valid |-> !h_req_ready); // R12

  AST_IREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid && !i_req_ready |=> i_req_valid && $stable(i_req_write)
      && $stable(i_req_addr) && $stable(i_req_wdata)); // R12

  AST_HRSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid && !h_rsp_ready |=> h_rsp_valid && $stable(h_rsp_data) && $stable(h_rsp_void)); // R12

endmodule

bind hbr_bridge hbr_bridge_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_valid (h_req_valid),
  .h_req_ready (h_req_ready),
  .h_req_write (h_req_write),
  .h_req_addr  (h_req_addr),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_ready (h_rsp_ready),
  .h_rsp_data  (h_rsp_data),
  .h_rsp_void  (h_rsp_void),
  .i_req_valid (i_req_valid),
  .i_req_ready (i_req_ready),
  .i_req_write (i_req_write),
  .i_req_addr  (i_req_addr),
  .i_req_wdata (i_req_wdata),
  .i_rsp_valid (i_rsp_valid)
);

// File: tb/hbr_bridge_tb_top.sv
module hbr_bridge_tb_top;

  localparam int AW  = 8;
  localparam int WAW = AW - 2;
  localparam int NW  = 1 << WAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           h_req_valid = 1'b0, h_req_write = 1'b0, h_req_bigend = 1'b0;
  logic [AW-1:1]  h_req_addr = '0;
  logic [15:0]    h_req_wdata = '0;
  logic           h_req_ready, h_rsp_valid, h_rsp_void;
  logic           h_rsp_ready = 1'b0;
  logic [15:0]    h_rsp_data;
  logic           i_req_valid, i_req_write;
  logic [WAW-1:0] i_req_addr;
  logic [31:0]    i_req_wdata;
  logic           i_req_ready, i_rsp_valid, i_rsp_hw16;
  logic [31:0]    i_rsp_data;

  hbr_bridge #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_write(h_req_write),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata), .h_req_bigend(h_req_bigend),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready), .h_rsp_data(h_rsp_data),
    .h_rsp_void(h_rsp_void),
    .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_write(i_req_write),
    .i_req_addr(i_req_addr), .i_req_wdata(i_req_wdata),
    .i_rsp_valid(i_rsp_valid), .i_rsp_data(i_rsp_data), .i_rsp_hw16(i_rsp_hw16)
  );

  function automatic logic [31:0] init_word(int k);
    return (32'(k) * 32'h0102_0408) ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [15:0] swap16(logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  function automatic logic [15:0] host_view(logic [31:0] w, logic a1, logic be);
    logic [15:0] h;
    h = (a1 ^ be) ? w[31:16] : w[15:0];
    return be ? swap16(h) : h;
  endfunction

  function automatic logic [31:0] put_half(logic [31:0] w, logic a1, logic be, logic [15:0] d);
    logic [15:0] v;
    v = be ? swap16(d) : d;
    if (a1 ^ be) w[31:16] = v;
    else         w[15:0]  = v;
    return w;
  endfunction

  // Register file model: random request stalls, one-cycle read latency,
  // words 0..3 flagged as 16-bit readable.
  logic [31:0]    regs [NW];
  int             wr_cnt, rd_cnt;
  logic [WAW-1:0] last_wa;
  logic [31:0]    last_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) regs[k] <= init_word(k);
      i_req_ready <= 1'b0;
      i_rsp_valid <= 1'b0;
      i_rsp_data  <= '0;
      i_rsp_hw16  <= 1'b0;
      wr_cnt      <= 0;
      rd_cnt      <= 0;
      last_wa     <= '0;
      last_wd     <= '0;
    end else begin
      i_req_ready <= ($urandom % 4) != 0;
      i_rsp_valid <= 1'b0;
      if (i_req_valid && i_req_ready) begin
        if (i_req_write) begin
          regs[i_req_addr] <= i_req_wdata;
          wr_cnt  <= wr_cnt + 1;
          last_wa <= i_req_addr;
          last_wd <= i_req_wdata;
        end else begin
          i_rsp_valid <= 1'b1;
          i_rsp_data  <= regs[i_req_addr];
          i_rsp_hw16  <= (i_req_addr < 4);
          rd_cnt      <= rd_cnt + 1;
        end
      end
    end
  end

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench copy of the expected bridge state.
  logic [31:0]    gold [NW];
  logic           wp_v = 1'b0, wp_h = 1'b0;
  logic [WAW-1:0] wp_a = '0;
  logic [31:0]    wp_buf = '0;
  logic           rp_v = 1'b0, rp_h = 1'b0;
  logic [WAW-1:0] rp_a = '0;
  logic [31:0]    rp_w = '0;

  task automatic host_write(logic [WAW-1:0] wa, logic a1, logic be, logic [15:0] d, string tag);
    logic p, fire;
    int wc0;
    p = a1 ^ be;
    fire = 1'b0;
    if (wp_v && wp_a == wa) begin
      wp_v = 1'b0;
      if (wp_h != p) begin
        fire = 1'b1;
        wp_buf = put_half(wp_buf, a1, be, d);
        gold[wa] = wp_buf;
      end
    end else begin
      wp_v = 1'b1; wp_h = p; wp_a = wa;
      wp_buf = put_half(wp_buf, a1, be, d);
    end
    wc0 = wr_cnt;
    @(negedge clk);
    h_req_valid = 1'b1; h_req_write = 1'b1; h_req_addr = {wa, a1};
    h_req_wdata = d; h_req_bigend = be;
    while (!h_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    h_req_valid = 1'b0;
    chk(i_req_valid == fire, {tag, " internal write due next cycle"}, 32'(i_req_valid), 32'(fire));
    if (fire) begin
      while (i_req_valid) @(negedge clk);
      chk(wr_cnt == wc0 + 1, {tag, " one internal write"}, wr_cnt, wc0 + 1);
      chk(last_wa == wa, {tag, " write address"}, 32'(last_wa), 32'(wa));
      chk(last_wd == wp_buf, {tag, " write data"}, last_wd, wp_buf);
    end else begin
      chk(wr_cnt == wc0, {tag, " no internal write"}, wr_cnt, wc0);
    end
  endtask

  task automatic host_read(logic [WAW-1:0] wa, logic a1, logic be, string tag);
    logic p, fetch, vd;
    logic [15:0] exp, d;
    int rc0, lat;
    p = a1 ^ be;
    fetch = 1'b0; vd = 1'b0;
    if (rp_v && rp_a == wa && rp_h != p) begin
      exp = host_view(rp_w, a1, be); rp_v = 1'b0;
    end else if (rp_v && rp_a == wa) begin
      exp = 16'h0000; vd = 1'b1; rp_v = 1'b0;
    end else begin
      fetch = 1'b1; rp_w = gold[wa]; exp = host_view(rp_w, a1, be);
      rp_v = (wa >= 4); rp_h = p; rp_a = wa;
    end
    rc0 = rd_cnt;
    @(negedge clk);
    h_req_valid = 1'b1; h_req_write = 1'b0; h_req_addr = {wa, a1}; h_req_bigend = be;
    while (!h_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    h_req_valid = 1'b0;
    if (fetch) chk(i_req_valid == 1'b1, {tag, " R6 fetch issued next cycle"}, 32'(i_req_valid), 1);
    lat = 1;
    while (!h_rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    if (!fetch) chk(lat == 1, {tag, " R7 reply latency"}, lat, 1);
    chk(h_rsp_data == exp, {tag, " read data"}, 32'(h_rsp_data), 32'(exp));
    chk(h_rsp_void == vd, {tag, " R8 void flag"}, 32'(h_rsp_void), 32'(vd));
    chk(h_req_ready == 1'b0, "R12 host not ready while reply pending", 32'(h_req_ready), 0);
    chk(rd_cnt == rc0 + int'(fetch), {tag, " internal read count"}, rd_cnt, rc0 + int'(fetch));
    if (($urandom % 3) == 0) begin
      d = h_rsp_data;
      @(negedge clk);
      chk(h_rsp_valid && h_rsp_data == d, "R12 stalled reply held",
          {15'h0, h_rsp_valid, h_rsp_data}, {15'h0, 1'b1, d});
    end
    h_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    h_rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R12 watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < NW; k++) gold[k] = init_word(k);
    repeat (5) @(negedge clk);
    chk(h_req_ready == 1'b1 && h_rsp_valid == 1'b0 && i_req_valid == 1'b0, "R1 in reset",
        {h_req_ready, h_rsp_valid, i_req_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(h_req_ready == 1'b1 && h_rsp_valid == 1'b0 && i_req_valid == 1'b0, "R1 after reset",
        {h_req_ready, h_rsp_valid, i_req_valid}, 3'b100);

    // R10: little-endian pair, low half first
    host_write(6'd9, 1'b0, 1'b0, 16'h2211, "R3");
    host_write(6'd9, 1'b1, 1'b0, 16'h4433, "R2");
    chk(last_wd == 32'h4433_2211, "R10 little-endian word", last_wd, 32'h4433_2211);
    host_read(6'd9, 1'b1, 1'b0, "R10");
    host_read(6'd9, 1'b0, 1'b0, "R7");

    // R11: big-endian pair, high internal half last
    host_write(6'd10, 1'b1, 1'b1, 16'hCCDD, "R3");
    host_write(6'd10, 1'b0, 1'b1, 16'hAABB, "R2");
    chk(last_wd == 32'hBBAA_DDCC, "R11 big-endian word", last_wd, 32'hBBAA_DDCC);
    host_read(6'd10, 1'b0, 1'b1, "R11");
    host_read(6'd10, 1'b0, 1'b0, "R11");

    // R4: repeated half drops the pair
    host_write(6'd11, 1'b0, 1'b0, 16'h1111, "R4");
    host_write(6'd11, 1'b0, 1'b0, 16'h2222, "R4");
    host_write(6'd11, 1'b1, 1'b0, 16'h3333, "R4");
    host_write(6'd11, 1'b0, 1'b0, 16'h4444, "R4");

    // R5: word address change restarts the pair
    host_write(6'd12, 1'b0, 1'b0, 16'h5555, "R5");
    host_write(6'd13, 1'b1, 1'b0, 16'h6666, "R5");
    host_write(6'd13, 1'b0, 1'b0, 16'h7777, "R5");
    chk(last_wa == 6'd13, "R5 new pair address", 32'(last_wa), 13);

    // R8: repeated read half is void, next read fetches
    host_read(6'd9, 1'b0, 1'b0, "R6");
    host_read(6'd9, 1'b0, 1'b0, "R8");
    host_read(6'd9, 1'b1, 1'b0, "R8");
    host_read(6'd9, 1'b0, 1'b0, "R7");

    // R9: 16-bit readable register needs no second read
    host_read(6'd2, 1'b0, 1'b0, "R9");
    host_read(6'd2, 1'b1, 1'b0, "R9");

    // R13: writes do not disturb an open read pair, and reads do not disturb an open write pair
    host_read(6'd14, 1'b1, 1'b0, "R13");
    host_write(6'd20, 1'b0, 1'b0, 16'h9999, "R13");
    host_read(6'd14, 1'b0, 1'b0, "R13");
    host_read(6'd20, 1'b0, 1'b0, "R13");
    host_write(6'd20, 1'b1, 1'b0, 16'h8888, "R13");

    // Constrained random mix over a small address window
    for (int n = 0; n < 600; n++) begin
      logic [WAW-1:0] wa;
      logic a1, be;
      wa = WAW'($urandom % 8);
      a1 = 1'($urandom);
      be = 1'($urandom);
      if (($urandom % 2) == 0) host_write(wa, a1, be, 16'($urandom), "R2");
      else                     host_read(wa, a1, be, "R6");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule